// File: doc/BRIEF.md
# Median-Mean Coefficient Pruning Engine

This block thins out a stored set of signed integer filter taps. On a start pulse it reads all N coefficients from an attached coefficient memory and sorts a copy of their magnitudes. It then runs two cuts. The first zeroes every tap whose magnitude is below the median magnitude. The second zeroes every surviving tap whose magnitude is below the mean magnitude of the survivors. The pruned set is written back to the same memory addresses. A surviving tap keeps its original value, sign included. The block computes no coefficients of its own and does all its arithmetic in integers.

The memory port is plain, with no handshake. A read issued in one cycle returns its data on `mem_rdata` in the next cycle. A write is taken in the cycle `mem_we` is high. The engine never stalls: the memory is expected to accept one access every cycle. Control is a start/done pair. `start` is sampled only while the engine is idle. When the run completes, `done` is high for exactly one cycle and `nz_count` is valid in that same cycle.

Top module: `coef_prune_engine`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `done`, `mem_we` and `mem_rd_en` are all low.
- R2: A start pulse in idle makes the engine read the N addresses 0 to N-1 once each, in ascending order, on consecutive cycles.
- R3: The median magnitude is computed on the magnitudes sorted in ascending order. For an even N it is the truncated average of the two middle sorted values. For an odd N it is the middle sorted value. The first cut keeps a coefficient when its magnitude is greater than or equal to this median and zeroes it otherwise.
- R4: After the first cut, s is the sum of the magnitudes and c is the count of non-zero coefficients. The mean is s/c, truncated. The second cut keeps a coefficient when its magnitude is greater than or equal to this mean and zeroes it otherwise.
- R5: A kept coefficient is written back bit-identical to the value read, including its sign. The most negative value, -2^(W-1), has magnitude 2^(W-1).
- R6: If no coefficient is non-zero after the first cut, the second cut is skipped, all N zeros are written back, and `nz_count` is 0.
- R7: Write-back covers addresses 0 to N-1 in ascending order, one write per cycle, and never overlaps a read.
- R8: `done` is high for exactly one cycle, in the cycle after the last write. In that cycle `nz_count` equals the number of non-zero coefficients written back.
- R9: A start pulse that arrives while a run is in progress is ignored: the run still reads N values, writes N values and produces a single `done`.
- R10: Both cuts keep magnitudes equal to the threshold. A set of identical magnitudes is therefore returned unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (sampled in idle only) |
| done | output | 1 | One-cycle completion pulse |
| nz_count | output | $clog2(N+1) | Final non-zero coefficient count, valid with `done` |
| mem_rd_en | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | $clog2(N) | Memory address for a read or a write |
| mem_wdata | output | W | Coefficient written back |
| mem_rdata | input | W | Read data, one cycle after `mem_rd_en` |

## Verification
The hardest outcomes to reach are the threshold ties and the empty second pass. A tie is a magnitude exactly equal to the median or to the mean. The empty second pass happens when nothing is non-zero after the first cut. Neither is visible at the ports unless the stored set is built to hit it. The stimulus table therefore contains four kinds of set. The first has all magnitudes equal, so both thresholds equal every value. The second has a zero median, and its survivors all share one magnitude. The third is all zeros. The fourth contains the most negative code, to test how the magnitude of that value is formed. A start pulse in the middle of a run is injected in a directed test, and the bench counts the done pulses and the memory accesses that follow.

// File: rtl/coef_prune_pkg.sv
package coef_prune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SORT,
    ST_CUT1,
    ST_CUT2,
    ST_WRITE,
    ST_DONE
  } prune_state_e;
endpackage

// File: rtl/mag_oet_sorter.sv
// In-place odd-even transposition network over a magnitude copy.
// One phase per step; N steps leave the bank in ascending order.
module mag_oet_sorter #(
  parameter int N  = 8,
  parameter int MW = 8,
  localparam int AW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic [AW-1:0]          ld_idx,
  input  logic [MW-1:0]          ld_val,
  input  logic                   step_en,
  input  logic                   odd_phase,
  output logic [N-1:0][MW-1:0]   mags
);
  logic [N-1:0][MW-1:0] nxt;

  always_comb begin
    nxt = mags;
    if (ld_en) nxt[ld_idx] = ld_val;
    if (step_en) begin
      // Pairs within one phase are disjoint, so in-loop swaps cannot collide.
      for (int i = 0; i < N - 1; i++) begin
        if (((i % 2) == 1) == odd_phase && mags[i] > mags[i+1]) begin
          nxt[i]   = mags[i+1];
          nxt[i+1] = mags[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mags <= '0;
    else        mags <= nxt;
  end
endmodule

// File: rtl/prune_stats.sv
// Median of sorted magnitudes, plus sum, non-zero count and mean of the
// current coefficient bank.
module prune_stats #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int CW = $clog2(N + 1),
  localparam int SW = W + $clog2(N)
) (
  input  logic [N-1:0][W-1:0] sorted,
  input  logic [N-1:0][W-1:0] coefs,
  output logic [N-1:0][W-1:0] mags_o,
  output logic [W-1:0]        median,
  output logic [W-1:0]        mean,
  output logic [CW-1:0]       nz
);
  logic [SW-1:0] sum;
  logic [SW-1:0] quot;

  always_comb begin
    sum = '0;
    nz  = '0;
    for (int i = 0; i < N; i++) begin
      mags_o[i] = coefs[i][W-1] ? (~coefs[i] + 1'b1) : coefs[i];
      sum = sum + SW'(mags_o[i]);
      if (mags_o[i] != '0) nz = nz + 1'b1;
    end
    quot = (nz == '0) ? '0 : sum / SW'(nz);
    mean = W'(quot);
  end

  generate
    if (N % 2 == 0) begin : g_even
      logic [W:0] pair;
      assign pair   = {1'b0, sorted[N/2-1]} + {1'b0, sorted[N/2]};
      assign median = pair[W:1];
    end else begin : g_odd
      assign median = sorted[N/2];
    end
  endgenerate
endmodule

// File: rtl/coef_prune_engine.sv
module coef_prune_engine
  import coef_prune_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int AW = $clog2(N),
  localparam int IW = $clog2(N + 1),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic [CW-1:0] nz_count,
  output logic          mem_rd_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);
  prune_state_e          state;
  logic [IW-1:0]         idx;
  logic                  cap_vld;
  logic [AW-1:0]         cap_idx;
  logic [N-1:0][W-1:0]   coef;
  logic [N-1:0][W-1:0]   sorted;
  logic [N-1:0][W-1:0]   mags;
  logic [W-1:0]          median;
  logic [W-1:0]          mean;
  logic [CW-1:0]         nz;
  logic [W-1:0]          rd_mag;

  assign rd_mag    = mem_rdata[W-1] ? (~mem_rdata + 1'b1) : mem_rdata;
  assign mem_rd_en = (state == ST_LOAD) && (idx < IW'(N));
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = idx[AW-1:0];
  assign mem_wdata = coef[idx[AW-1:0]];
  assign done      = (state == ST_DONE);
  assign nz_count  = nz;

  mag_oet_sorter #(.N(N), .MW(W)) u_sort (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (cap_vld),
    .ld_idx    (cap_idx),
    .ld_val    (rd_mag),
    .step_en   (state == ST_SORT),
    .odd_phase (idx[0]),
    .mags      (sorted)
  );

  prune_stats #(.N(N), .W(W)) u_stats (
    .sorted (sorted),
    .coefs  (coef),
    .mags_o (mags),
    .median (median),
    .mean   (mean),
    .nz     (nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      cap_vld <= 1'b0;
      cap_idx <= '0;
      coef    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LOAD;
            idx   <= '0;
          end
        end
        ST_LOAD: begin
          cap_vld <= mem_rd_en;
          cap_idx <= idx[AW-1:0];
          if (mem_rd_en) idx <= idx + 1'b1;
          if (cap_vld) coef[cap_idx] <= mem_rdata;
          if (cap_vld && cap_idx == AW'(N - 1)) begin
            state <= ST_SORT;
            idx   <= '0;
          end
        end
        ST_SORT: begin
          idx <= idx + 1'b1;
          if (idx == IW'(N - 1)) state <= ST_CUT1;
        end
        ST_CUT1: begin
          for (int i = 0; i < N; i++)
            if (mags[i] < median) coef[i] <= '0;
          state <= ST_CUT2;
        end
        ST_CUT2: begin
          if (nz != '0)
            for (int i = 0; i < N; i++)
              if (mags[i] < mean) coef[i] <= '0;
          state <= ST_WRITE;
          idx   <= '0;
        end
        ST_WRITE: begin
          idx <= idx + 1'b1;
          if (idx == IW'(N - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coef_prune_checker.sv
module coef_prune_checker #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [CW-1:0] nz_count,
  input logic          mem_rd_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows the write to the last address
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_we) && $past(mem_addr) == AW'(N - 1)));

  // R8: reported count never exceeds the set size
  p_nz_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nz_count <= CW'(N)));

  // R2: reads on consecutive cycles step up by one address
  p_rd_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R7: writes on consecutive cycles step up by one address
  p_wr_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R7: a write never coincides with a read
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_rd_en));

  // R2: the first read of a run targets address 0
  p_rd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |-> (mem_addr == '0));
endmodule

bind coef_prune_engine coef_prune_checker #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .nz_count  (nz_count),
  .mem_rd_en (mem_rd_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/coef_prune_engine_tb.sv
module coef_prune_engine_tb;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam int NV = 6;

  // Each row: N coefficients, then the hand-derived final non-zero count.
  localparam int VEC [NV][N+1] = '{
    '{  10,  -3,   7,   0, -20,   5,   1,  -8, 1},
    '{-128, 127,   1,  -1,  64, -64,   2,   3, 2},
    '{   5,   5,  -5,   5,   5,  -5,   5,   5, 8},
    '{   0,   0,   0,   0,   0,   0,   0,   0, 0},
    '{   1,   2,   3,   4,   5,   6,   7,   8, 3},
    '{  -9,   9,  -9,   0,   0,   0,   0,   0, 3}
  };

  typedef int vec_t [N];

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          done;
  logic [CW-1:0] nz_count;
  logic          mem_rd_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata;

  logic [W-1:0]  mem [N];
  int checks, errors;
  int rd_cnt, wr_cnt, done_cnt, order_err;
  int exp_rd, exp_wr;

  coef_prune_engine #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .nz_count(nz_count),
    .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Memory model with one-cycle read latency; tracks access order.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      if (int'(mem_addr) != exp_rd) order_err <= order_err + 1;
      exp_rd <= exp_rd + 1;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (int'(mem_addr) != exp_wr) order_err <= order_err + 1;
      exp_wr <= exp_wr + 1;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic void ref_model(input vec_t c, output vec_t o, output int nz);
    int m [N];
    int t, med, s, cnt, mean;
    for (int i = 0; i < N; i++) m[i] = iabs(c[i]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (m[j] > m[j+1]) begin t = m[j]; m[j] = m[j+1]; m[j+1] = t; end
    med = (N % 2 == 0) ? (m[N/2-1] + m[N/2]) / 2 : m[N/2];
    s = 0; cnt = 0;
    for (int i = 0; i < N; i++) begin
      o[i] = (iabs(c[i]) >= med) ? c[i] : 0;
      s += iabs(o[i]);
      if (o[i] != 0) cnt++;
    end
    if (cnt != 0) begin
      mean = s / cnt;
      for (int i = 0; i < N; i++) if (iabs(o[i]) < mean) o[i] = 0;
    end
    nz = 0;
    for (int i = 0; i < N; i++) if (o[i] != 0) nz++;
  endfunction

  // Loads memory, starts a run (optionally re-pulsing start mid-run),
  // waits for done and returns the count sampled with it.
  task automatic run(input vec_t c, input bit extra_start, output int nz_seen, output bit timed_out);
    for (int i = 0; i < N; i++) mem[i] = W'(c[i]);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; order_err = 0; exp_rd = 0; exp_wr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    timed_out = 1'b1;
    nz_seen = -1;
    for (int k = 0; k < 1000; k++) begin
      if (extra_start && k == 5) start = 1'b1;
      if (extra_start && k == 6) start = 1'b0;
      if (done) begin
        nz_seen = int'(nz_count);
        timed_out = 1'b0;
        break;
      end
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic check_result(input vec_t c, input string tag, input int hand_nz);
    vec_t exp_o;
    int exp_nz;
    ref_model(c, exp_o, exp_nz);
    for (int i = 0; i < N; i++)
      check(mem[i] == W'(exp_o[i]), tag, int'($signed(mem[i])), exp_o[i]);
    check(exp_nz == hand_nz, {tag, " model-vs-table"}, exp_nz, hand_nz);
  endtask

  initial begin
    vec_t c;
    int nz_seen;
    bit to;
    checks = 0; errors = 0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; order_err = 0; exp_rd = 0; exp_wr = 0;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(!done && !mem_we && !mem_rd_en, "R1 reset", {done, mem_we, mem_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_we && !mem_rd_en, "R1 after release", {done, mem_we, mem_rd_en}, 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < N; i++) c[i] = VEC[v][i];
      run(c, 1'b0, nz_seen, to);
      check(!to, "R8 watchdog", int'(to), 0);
      check_result(c, "R3 R4 coefficients", VEC[v][N]);
      check(nz_seen == VEC[v][N], "R8 nz_count", nz_seen, VEC[v][N]);
      check(done_cnt == 1, "R8 single done", done_cnt, 1);
      check(rd_cnt == N, "R2 read count", rd_cnt, N);
      check(wr_cnt == N, "R7 write count", wr_cnt, N);
      check(order_err == 0, "R2 R7 address order", order_err, 0);
    end

    // R3 R4 hand-derived: median 6, mean 11, only -20 survives
    c = '{10, -3, 7, 0, -20, 5, 1, -8};
    run(c, 1'b0, nz_seen, to);
    check(mem[4] == 8'hEC, "R3 R4 survivor", int'($signed(mem[4])), -20);
    check(mem[0] == 8'h00 && mem[2] == 8'h00 && mem[7] == 8'h00, "R4 mean cut", int'(mem[0]), 0);

    // R5: most negative code kept with its sign
    c = '{-128, 127, 1, -1, 64, -64, 2, 3};
    run(c, 1'b0, nz_seen, to);
    check(mem[0] == 8'h80, "R5 min code kept", int'($signed(mem[0])), -128);
    check(mem[1] == 8'h7F, "R5 max code kept", int'(mem[1]), 127);

    // R6: all-zero set
    c = '{0, 0, 0, 0, 0, 0, 0, 0};
    run(c, 1'b0, nz_seen, to);
    check(nz_seen == 0, "R6 empty count", nz_seen, 0);

    // R10: equal magnitudes all kept
    c = '{-3, 3, 3, -3, 3, 3, 3, -3};
    run(c, 1'b0, nz_seen, to);
    check(mem[0] == 8'hFD && mem[1] == 8'h03, "R10 ties kept", int'($signed(mem[0])), -3);
    check(nz_seen == 8, "R10 ties count", nz_seen, 8);

    // R9: extra start mid-run ignored
    c = '{10, -3, 7, 0, -20, 5, 1, -8};
    run(c, 1'b1, nz_seen, to);
    check(done_cnt == 1, "R9 one done", done_cnt, 1);
    check(rd_cnt == N, "R9 reads", rd_cnt, N);
    check(wr_cnt == N, "R9 writes", wr_cnt, N);
    check(nz_seen == 1, "R9 result", nz_seen, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 global watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule